// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block decides, for each received CAN identifier, whether the message is kept and which receive buffer takes it. A bank of filters is compared in parallel against the incoming identifier. Each filter holds a reference identifier, a frame-type bit, an enable, a pointer to a destination buffer and a selector that picks one of a few shared masks. The mask says which identifier bits must equal the filter's bits and whether the frame type must agree as well.

The block also keeps one full flag per receive buffer. A filter whose buffer is still full does not take the message. The next matching filter that has an empty buffer takes it instead, so software can give one identifier several buffers and absorb bursts. The block sets a full flag when it accepts a message, and the host clears that flag once the buffer has been read. A message that matches only full buffers is dropped and reported with an overflow strobe.

Results are registered. The accept strobe, buffer index, filter number and overflow strobe appear one clock after the identifier is presented.

Top module: `can_accept_filter`

## Requirements
- R1: For a filter using a mask, an identifier bit whose mask bit is 1 must equal the filter bit. An identifier bit whose mask bit is 0 is ignored.
- R2: A standard frame (rx_xtd_i = 0) compares only identifier bits [10:0], and bits [28:11] of rx_id_i have no effect. An extended frame compares bits [28:0].
- R3: When the selected mask's type-check bit is 1, rx_xtd_i must equal the filter's type bit. When it is 0, both frame types can match.
- R4: A filter's 2-bit mask selector value 0, 1 or 2 selects that mask. Value 3 selects no mask, so every identifier bit is ignored and there is no type check.
- R5: A filter whose enable bit is 0 never matches.
- R6: One cycle after rx_valid_i, acc_o pulses for one cycle if the message was accepted. acc_buf_o then holds the winning filter's 4-bit buffer pointer and acc_filt_o holds that filter's number.
- R7: Matching filters whose buffer is full are skipped. Among the remaining matching filters, the lowest-numbered one wins.
- R8: If at least one filter matches but every matching filter points to a full buffer, ovf_o pulses one cycle after rx_valid_i and no full flag is set. If no filter matches, neither acc_o nor ovf_o pulses.
- R9: On acceptance, bit acc_buf_o of buf_full_o is set in the same cycle acc_o pulses. It stays set until a 1 on that bit of buf_clr_i, which clears it one cycle later. A set and a clear of the same buffer in the same cycle leave the flag set.
- R10: After reset, acc_o, ovf_o and all full flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Identifier valid, one cycle per message |
| rx_id_i | input | 29 | Received identifier; standard uses [10:0] |
| rx_xtd_i | input | 1 | 1 = extended frame |
| filt_id_i | input | 16*29 | Filter reference identifiers, filter f at [f*29 +: 29] |
| filt_xtd_i | input | 16 | Filter frame-type bits |
| filt_en_i | input | 16 | Filter enables |
| filt_msel_i | input | 16*2 | Mask selector per filter |
| filt_bptr_i | input | 16*4 | Destination buffer per filter |
| mask_val_i | input | 3*29 | Mask bits, mask m at [m*29 +: 29] |
| mask_ide_i | input | 3 | Type-check bit per mask |
| buf_clr_i | input | 16 | Full-flag clear, one bit per buffer |
| acc_o | output | 1 | Accept strobe |
| acc_buf_o | output | 4 | Destination buffer of accepted message |
| acc_filt_o | output | 4 | Number of the filter that accepted |
| ovf_o | output | 1 | Overflow strobe (all matching buffers full) |
| buf_full_o | output | 16 | Buffer full flags |

## Verification
Every result is due one clock after the stimulus that causes it. Accept, overflow, buffer index, filter number and a newly set full flag all follow the rx_valid_i edge by one clock, and a clear takes effect one clock after buf_clr_i. The bench changes inputs on the falling edge and reads outputs on the next falling edge, after exactly one rising edge. Its expected values come from a model of the filter configuration and the buffer states, updated at that same point.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  localparam int unsigned CAN_ID_W  = 29;
  localparam int unsigned CAN_STD_W = 11;
  localparam int unsigned N_FILT    = 16;
  localparam int unsigned N_MASK    = 3;
  localparam int unsigned MSEL_W    = 2;
  localparam int unsigned BPTR_W    = 4;
endpackage

// File: rtl/can_filt_match.sv
module can_filt_match #(
  parameter int unsigned ID_W   = can_acc_pkg::CAN_ID_W,
  parameter int unsigned STD_W  = can_acc_pkg::CAN_STD_W,
  parameter int unsigned N_MASK = can_acc_pkg::N_MASK,
  parameter int unsigned MSEL_W = can_acc_pkg::MSEL_W
) (
  input  logic [ID_W-1:0]        id_i,
  input  logic                   xtd_i,
  input  logic [ID_W-1:0]        fid_i,
  input  logic                   fxtd_i,
  input  logic                   en_i,
  input  logic [MSEL_W-1:0]      msel_i,
  input  logic [N_MASK*ID_W-1:0] masks_i,
  input  logic [N_MASK-1:0]      mide_i,
  output logic                   hit_o
);
  localparam logic [ID_W-1:0] STD_CARE = {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};

  logic [ID_W-1:0] sel_mask, care, diff;
  logic            sel_ide, type_ok;

  // selector values beyond the mask count leave every bit don't-care
  always_comb begin
    sel_mask = '0;
    sel_ide  = 1'b0;
    for (int k = 0; k < int'(N_MASK); k++) begin
      if (msel_i == MSEL_W'(k)) begin
        sel_mask = masks_i[k*ID_W +: ID_W];
        sel_ide  = mide_i[k];
      end
    end
  end

  assign care    = xtd_i ? '1 : STD_CARE;
  assign diff    = (id_i ^ fid_i) & sel_mask & care;
  assign type_ok = !sel_ide || (xtd_i == fxtd_i);
  assign hit_o   = en_i && (diff == '0) && type_ok;
endmodule

// File: rtl/can_filt_pick.sv
module can_filt_pick #(
  parameter int unsigned N     = can_acc_pkg::N_FILT,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan downward so the lowest index is written last
  always_comb begin
    idx_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/can_buf_flags.sv
module can_buf_flags #(
  parameter int unsigned IDX_W = can_acc_pkg::BPTR_W,
  parameter int unsigned N_BUF = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic [N_BUF-1:0] clr_i,
  output logic [N_BUF-1:0] full_o
);
  logic [N_BUF-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    if (set_i) set_vec[set_idx_i] = 1'b1;
  end

  // set has priority over a clear of the same buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_o <= '0;
    else         full_o <= (full_o & ~clr_i) | set_vec;
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter #(
  parameter int unsigned NUM_FILT = can_acc_pkg::N_FILT,
  parameter int unsigned NUM_MASK = can_acc_pkg::N_MASK,
  parameter int unsigned MSEL_W   = can_acc_pkg::MSEL_W,
  parameter int unsigned BPTR_W   = can_acc_pkg::BPTR_W,
  parameter int unsigned ID_W     = can_acc_pkg::CAN_ID_W,
  parameter int unsigned STD_W    = can_acc_pkg::CAN_STD_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rx_valid_i,
  input  logic [ID_W-1:0]              rx_id_i,
  input  logic                         rx_xtd_i,
  input  logic [NUM_FILT*ID_W-1:0]     filt_id_i,
  input  logic [NUM_FILT-1:0]          filt_xtd_i,
  input  logic [NUM_FILT-1:0]          filt_en_i,
  input  logic [NUM_FILT*MSEL_W-1:0]   filt_msel_i,
  input  logic [NUM_FILT*BPTR_W-1:0]   filt_bptr_i,
  input  logic [NUM_MASK*ID_W-1:0]     mask_val_i,
  input  logic [NUM_MASK-1:0]          mask_ide_i,
  input  logic [(1<<BPTR_W)-1:0]       buf_clr_i,
  output logic                         acc_o,
  output logic [BPTR_W-1:0]            acc_buf_o,
  output logic [$clog2(NUM_FILT)-1:0]  acc_filt_o,
  output logic                         ovf_o,
  output logic [(1<<BPTR_W)-1:0]       buf_full_o
);
  localparam int unsigned NUM_BUF = 1 << BPTR_W;
  localparam int unsigned FIDX_W  = $clog2(NUM_FILT);

  logic [NUM_FILT-1:0] hit, elig;
  logic                any_elig;
  logic [FIDX_W-1:0]   win_idx;
  logic [BPTR_W-1:0]   win_buf;
  logic                do_set, do_ovf;

  for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
    can_filt_match #(
      .ID_W(ID_W), .STD_W(STD_W), .N_MASK(NUM_MASK), .MSEL_W(MSEL_W)
    ) u_match (
      .id_i   (rx_id_i),
      .xtd_i  (rx_xtd_i),
      .fid_i  (filt_id_i[f*ID_W +: ID_W]),
      .fxtd_i (filt_xtd_i[f]),
      .en_i   (filt_en_i[f]),
      .msel_i (filt_msel_i[f*MSEL_W +: MSEL_W]),
      .masks_i(mask_val_i),
      .mide_i (mask_ide_i),
      .hit_o  (hit[f])
    );
    assign elig[f] = hit[f] && !buf_full_o[filt_bptr_i[f*BPTR_W +: BPTR_W]];
  end

  can_filt_pick #(.N(NUM_FILT), .IDX_W(FIDX_W)) u_pick (
    .req_i(elig),
    .any_o(any_elig),
    .idx_o(win_idx)
  );

  assign win_buf = filt_bptr_i[win_idx*BPTR_W +: BPTR_W];
  assign do_set  = rx_valid_i && any_elig;
  assign do_ovf  = rx_valid_i && !any_elig && (|hit);

  can_buf_flags #(.IDX_W(BPTR_W), .N_BUF(NUM_BUF)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (do_set),
    .set_idx_i(win_buf),
    .clr_i    (buf_clr_i),
    .full_o   (buf_full_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o      <= 1'b0;
      ovf_o      <= 1'b0;
      acc_buf_o  <= '0;
      acc_filt_o <= '0;
    end else begin
      acc_o <= do_set;
      ovf_o <= do_ovf;
      if (do_set) begin
        acc_buf_o  <= win_buf;
        acc_filt_o <= win_idx;
      end
    end
  end
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
  parameter int unsigned NUM_FILT = can_acc_pkg::N_FILT,
  parameter int unsigned NUM_MASK = can_acc_pkg::N_MASK,
  parameter int unsigned MSEL_W   = can_acc_pkg::MSEL_W,
  parameter int unsigned BPTR_W   = can_acc_pkg::BPTR_W,
  parameter int unsigned ID_W     = can_acc_pkg::CAN_ID_W
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        rx_valid_i,
  input logic [(1<<BPTR_W)-1:0]      buf_clr_i,
  input logic                        acc_o,
  input logic [BPTR_W-1:0]           acc_buf_o,
  input logic                        ovf_o,
  input logic [(1<<BPTR_W)-1:0]      buf_full_o
);
  // R6
  acc_after_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |-> $past(rx_valid_i));

  // R8
  ovf_after_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(rx_valid_i));

  // R8
  acc_ovf_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |-> !ovf_o);

  // R8
  ovf_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && $past(buf_clr_i) == '0) |-> $stable(buf_full_o));

  // R9
  acc_sets_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |-> buf_full_o[acc_buf_o]);

  for (genvar b = 0; b < (1 << BPTR_W); b++) begin : g_buf
    // R9
    full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(buf_full_o[b]) |-> $past(buf_clr_i[b]));
  end
endmodule

bind can_accept_filter can_accept_filter_chk #(
  .NUM_FILT(NUM_FILT), .NUM_MASK(NUM_MASK), .MSEL_W(MSEL_W),
  .BPTR_W(BPTR_W), .ID_W(ID_W)
) u_chk (.*);

// File: tb/can_accept_filter_test.sv
module can_accept_filter_test;
  localparam int NF = 16, NM = 3, IW = 29;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          rx_valid = 1'b0, rx_xtd = 1'b0;
  logic [IW-1:0] rx_id = '0;
  logic [15:0]   buf_clr = '0;
  logic [NF*IW-1:0] p_fid;
  logic [NF-1:0]    p_fxt, p_fen;
  logic [NF*2-1:0]  p_ms;
  logic [NF*4-1:0]  p_bp;
  logic [NM*IW-1:0] p_mv;
  logic [NM-1:0]    p_mi;
  logic        acc, ovf;
  logic [3:0]  acc_buf, acc_filt;
  logic [15:0] full;

  logic [IW-1:0] c_fid[NF];
  logic          c_fxt[NF], c_fen[NF];
  logic [1:0]    c_ms[NF];
  logic [3:0]    c_bp[NF];
  logic [IW-1:0] c_mv[NM];
  logic          c_mi[NM];
  logic [15:0]   mfull = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always_comb begin
    for (int f = 0; f < NF; f++) begin
      p_fid[f*IW +: IW] = c_fid[f];
      p_fxt[f] = c_fxt[f];
      p_fen[f] = c_fen[f];
      p_ms[f*2 +: 2] = c_ms[f];
      p_bp[f*4 +: 4] = c_bp[f];
    end
    for (int m = 0; m < NM; m++) begin
      p_mv[m*IW +: IW] = c_mv[m];
      p_mi[m] = c_mi[m];
    end
  end

  can_accept_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_id_i(rx_id),
    .rx_xtd_i(rx_xtd), .filt_id_i(p_fid), .filt_xtd_i(p_fxt), .filt_en_i(p_fen),
    .filt_msel_i(p_ms), .filt_bptr_i(p_bp), .mask_val_i(p_mv), .mask_ide_i(p_mi),
    .buf_clr_i(buf_clr), .acc_o(acc), .acc_buf_o(acc_buf), .acc_filt_o(acc_filt),
    .ovf_o(ovf), .buf_full_o(full)
  );

  task automatic chk(bit ok, string tag, int unsigned act, int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected match from R1..R5
  function automatic bit exp_hit(int f, logic [IW-1:0] id, logic x);
    logic [IW-1:0] m, care;
    logic t;
    if (!c_fen[f]) return 0;
    if (c_ms[f] == 2'd3) begin m = '0; t = 0; end
    else begin m = c_mv[c_ms[f]]; t = c_mi[c_ms[f]]; end
    care = x ? {IW{1'b1}} : 29'h7FF;
    if ((((id ^ c_fid[f]) & care) & m) != '0) return 0;
    if (t && (x != c_fxt[f])) return 0;
    return 1;
  endfunction

  task automatic send(logic [IW-1:0] id, logic x, logic [15:0] clr, string tag);
    int win = -1;
    bit anyh = 0;
    logic [15:0] nf;
    for (int f = 0; f < NF; f++)
      if (exp_hit(f, id, x)) begin
        anyh = 1;
        if (win < 0 && !mfull[c_bp[f]]) win = f;
      end
    @(negedge clk);
    rx_valid = 1'b1; rx_id = id; rx_xtd = x; buf_clr = clr;
    @(negedge clk);
    rx_valid = 1'b0; buf_clr = '0;
    nf = mfull & ~clr;
    if (win >= 0) nf[c_bp[win]] = 1'b1;
    mfull = nf;
    chk(acc == (win >= 0), tag, acc, win >= 0);
    if (win >= 0) begin
      chk(acc_buf == c_bp[win], tag, acc_buf, c_bp[win]);
      chk(acc_filt == 4'(win), tag, acc_filt, win);
    end
    chk(ovf == (anyh && win < 0), tag, ovf, anyh && win < 0);
    chk(full == mfull, tag, full, mfull);
  endtask

  task automatic clear(logic [15:0] m);
    @(negedge clk);
    buf_clr = m;
    @(negedge clk);
    buf_clr = '0;
    mfull &= ~m;
    chk(full == mfull && !acc && !ovf, "R9", full, mfull);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < NF; f++) begin
      c_fid[f] = '0; c_fxt[f] = 0; c_fen[f] = 0; c_ms[f] = 2'd0; c_bp[f] = 4'(f);
    end
    c_mv[0] = 29'h7FF;       c_mi[0] = 1;
    c_mv[1] = 29'h1FFFFFFF;  c_mi[1] = 1;
    c_mv[2] = 29'h7F0;       c_mi[2] = 0;
    c_fid[0] = 29'h123;     c_fen[0] = 1; c_ms[0] = 0; c_bp[0] = 4'd1;
    c_fid[1] = 29'h1234568; c_fxt[1] = 1; c_fen[1] = 1; c_ms[1] = 1; c_bp[1] = 4'd2;
    c_fid[2] = 29'h120;     c_fen[2] = 1; c_ms[2] = 2; c_bp[2] = 4'd3;
    c_fid[3] = 29'h555;     c_fen[3] = 0; c_ms[3] = 3; c_bp[3] = 4'd4;

    repeat (3) @(negedge clk);
    chk(acc == 0 && ovf == 0 && full == 0, "R10", {acc, ovf, full}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(acc == 0 && ovf == 0 && full == 0, "R10", {acc, ovf, full}, 0);

    // R1 R5: all standard identifiers, filter 3 disabled
    for (int i = 0; i < 2048; i++) begin
      send(29'(i), 1'b0, '0, "R1");
      if (mfull != 0) clear(16'hFFFF);
    end

    // R2: upper bits ignored on standard frames; extended bit flips
    send(29'h1FFFF800 | 29'h123, 1'b0, '0, "R2");
    clear(16'hFFFF);
    send(29'h1234568, 1'b1, '0, "R2");
    clear(16'hFFFF);
    for (int b = 0; b < IW; b++) begin
      send(29'h1234568 ^ (29'd1 << b), 1'b1, '0, "R2");
      if (mfull != 0) clear(16'hFFFF);
    end

    // R3: type check on mask 0, none on mask 2
    send(29'h123, 1'b1, '0, "R3");
    clear(16'hFFFF);
    send(29'h12F, 1'b1, '0, "R3");
    clear(16'hFFFF);
    send(29'h1234568, 1'b0, '0, "R3");
    clear(16'hFFFF);

    // R4: selector 3 accepts anything once enabled
    c_fen[3] = 1;
    send(29'h0AB, 1'b0, '0, "R4");
    send(29'h1ABCDEF, 1'b1, '0, "R4");
    clear(16'hFFFF);
    c_fen[3] = 0;
    send(29'h0AB, 1'b0, '0, "R5");

    // R7 R8: fall through to other buffers, then overflow
    c_fid[5] = 29'h123; c_fen[5] = 1; c_ms[5] = 0; c_bp[5] = 4'd5;
    c_fid[6] = 29'h123; c_fen[6] = 1; c_ms[6] = 0; c_bp[6] = 4'd6;
    for (int k = 0; k < 4; k++) send(29'h123, 1'b0, '0, "R7");
    send(29'h123, 1'b0, '0, "R8");
    send(29'h7FF, 1'b0, '0, "R8");
    clear(16'h0020);
    send(29'h123, 1'b0, '0, "R7");
    send(29'h123, 1'b0, '0, "R6");

    // R9: set and clear of the same buffer together
    clear(16'h0002);
    send(29'h123, 1'b0, 16'h0002, "R9");
    chk(full[1] == 1'b1, "R9", full[1], 1);
    clear(16'hFFFF);

    // mixed traffic with random clears
    for (int f = 7; f < NF; f++) begin
      c_fid[f] = 29'($urandom); c_fxt[f] = f[0]; c_fen[f] = 1;
      c_ms[f] = 2'(f % 4); c_bp[f] = 4'($urandom);
    end
    for (int n = 0; n < 3000; n++) begin
      int f = int'($urandom % NF);
      logic [IW-1:0] id = c_fid[f] ^ 29'($urandom & 32'h13);
      send(id, 1'($urandom), 16'($urandom & $urandom), "R7");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule